// File: doc/BRIEF.md
# Carry-Lookahead Adder

This block adds two WIDTH-bit operands and a carry-in, and returns a WIDTH-bit sum and a carry-out. It is purely combinational. The operand columns are split into groups of BLK bits. Each column forms a generate term (both operand bits set) and a propagate term (either operand bit set).

Each group reduces its column terms to a single group generate and a single group propagate. The carry then hops from one group to the next through one AND/OR stage per group, and does not ripple through every column. Inside a group, the sum bits still come from a short ripple seeded by the carry that enters that group.

The default build is a 32-bit adder made of eight 4-bit groups. A WIDTH that is not a whole multiple of BLK stops elaboration.

Top module: `lookahead_adder`

## Requirements
- R1: For every operand pair and carry-in, sumOut equals the low WIDTH bits of opA + opB + carryIn.
- R2: carryOut equals bit WIDTH of opA + opB + carryIn. For example, 0x80000000 + 0x80000000 with carryIn 0 gives sum 0 and carryOut 1.
- R3: With opA all ones, opB zero and carryIn 1, the carry travels through every group: sumOut is 0 and carryOut is 1.
- R4: With both operands all ones, every column generates. With carryIn 0, sumOut is 0xFFFFFFFE and carryOut is 1. With carryIn 1, sumOut is 0xFFFFFFFF and carryOut is 1.
- R5: When opA XOR opB is all ones and carryIn is 0, no carry is created anywhere: sumOut is all ones and carryOut is 0.
- R6: The carry entering group j equals the carry out of the addition of columns 0 to BLK*j-1 plus carryIn. It shows up at the first sum bit of that group, for example 0x0FFFFFFF + 1 = 0x10000000.
- R7: With opB zero and carryIn 0, sumOut equals opA unchanged and carryOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into column 0 |
| sumOut | output | WIDTH | Sum bits |
| carryOut | output | 1 | Carry out of the top column |

## Verification
The bench builds the adder with its default of 32 bits and 4-bit groups. That gives eight groups, so a carry can cross seven group boundaries. Operand patterns can then reach a carry born in group 0 that must skip to the top, a carry killed inside a group, and a carry created in one group that only propagates in the groups above. Corner vectors cover each of these paths, and random operands cover mixed generate and propagate patterns across all group boundaries.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } pgPair_t;

  function automatic int groupCount(input int width, input int blk);
    return width / blk;
  endfunction

endpackage

// File: rtl/lookahead_pg.sv
module lookahead_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] colGen,
  output logic [WIDTH-1:0] colProp
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    assign colGen[i]  = opA[i] & opB[i];
    assign colProp[i] = opA[i] | opB[i];
  end

endmodule

// File: rtl/lookahead_group.sv
module lookahead_group
  import lookahead_pkg::*;
#(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] colGen,
  input  logic [BLK-1:0] colProp,
  output pgPair_t        grpTerm
);

  always_comb begin
    grpTerm.gen  = colGen[0];
    grpTerm.prop = colProp[0];
    for (int i = 1; i < BLK; i++) begin
      grpTerm.gen  = colGen[i] | (colProp[i] & grpTerm.gen);
      grpTerm.prop = grpTerm.prop & colProp[i];
    end
  end

endmodule

// File: rtl/lookahead_skip.sv
module lookahead_skip #(
  parameter int GROUPS = 8
) (
  input  logic              carryIn,
  input  logic [GROUPS-1:0] grpGen,
  input  logic [GROUPS-1:0] grpProp,
  output logic [GROUPS:0]   blkCarry
);

  assign blkCarry[0] = carryIn;

  for (genvar j = 0; j < GROUPS; j++) begin : g_hop
    assign blkCarry[j+1] = grpGen[j] | (grpProp[j] & blkCarry[j]);
  end

endmodule

// File: rtl/lookahead_ripple.sv
module lookahead_ripple #(
  parameter int BLK = 4
) (
  input  logic           carryIn,
  input  logic [BLK-1:0] opA,
  input  logic [BLK-1:0] opB,
  input  logic [BLK-1:0] colGen,
  input  logic [BLK-1:0] colProp,
  output logic [BLK-1:0] sumBits
);

  logic [BLK:0] ripCarry;

  assign ripCarry[0] = carryIn;

  for (genvar i = 0; i < BLK; i++) begin : g_bit
    assign sumBits[i]    = opA[i] ^ opB[i] ^ ripCarry[i];
    assign ripCarry[i+1] = colGen[i] | (colProp[i] & ripCarry[i]);
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  localparam int GROUPS = groupCount(WIDTH, BLK);

  if ((WIDTH % BLK) != 0 || BLK < 1) begin : g_bad_cfg
    $error("lookahead_adder: WIDTH must be a whole multiple of BLK");
  end

  logic [WIDTH-1:0]  colGen;
  logic [WIDTH-1:0]  colProp;
  logic [GROUPS-1:0] grpGen;
  logic [GROUPS-1:0] grpProp;
  logic [GROUPS:0]   blkCarry;

  lookahead_pg #(.WIDTH(WIDTH)) pg_i (
    .opA    (opA),
    .opB    (opB),
    .colGen (colGen),
    .colProp(colProp)
  );

  for (genvar j = 0; j < GROUPS; j++) begin : g_grp
    pgPair_t term;

    lookahead_group #(.BLK(BLK)) grp_i (
      .colGen (colGen[j*BLK +: BLK]),
      .colProp(colProp[j*BLK +: BLK]),
      .grpTerm(term)
    );

    assign grpGen[j]  = term.gen;
    assign grpProp[j] = term.prop;

    lookahead_ripple #(.BLK(BLK)) rip_i (
      .carryIn(blkCarry[j]),
      .opA    (opA[j*BLK +: BLK]),
      .opB    (opB[j*BLK +: BLK]),
      .colGen (colGen[j*BLK +: BLK]),
      .colProp(colProp[j*BLK +: BLK]),
      .sumBits(sumOut[j*BLK +: BLK])
    );
  end

  lookahead_skip #(.GROUPS(GROUPS)) skip_i (
    .carryIn (carryIn),
    .grpGen  (grpGen),
    .grpProp (grpProp),
    .blkCarry(blkCarry)
  );

  assign carryOut = blkCarry[GROUPS];

endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
  parameter int WIDTH  = 32,
  parameter int GROUPS = 8,
  parameter int BLK    = 4
) (
  input logic [WIDTH-1:0]  opA,
  input logic [WIDTH-1:0]  opB,
  input logic              carryIn,
  input logic [WIDTH-1:0]  sumOut,
  input logic              carryOut,
  input logic [GROUPS:0]   blkCarry
);

  logic [WIDTH:0] refSum;

  always_comb begin
    refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

    // R1
    sum_value_chk: assert (sumOut == refSum[WIDTH-1:0]);

    // R2
    carry_out_chk: assert (carryOut == refSum[WIDTH]);

    // R3
    if (((opA ^ opB) == '1) && carryIn) begin
      full_prop_chk: assert (sumOut == '0 && carryOut);
    end

    // R5
    if (((opA ^ opB) == '1) && !carryIn) begin
      no_spurious_carry_chk: assert (sumOut == '1 && !carryOut);
    end

    // R6
    for (int j = 0; j < GROUPS; j++) begin
      group_carry_chk: assert (blkCarry[j] ==
        (refSum[j*BLK] ^ opA[j*BLK] ^ opB[j*BLK]));
    end
  end

endmodule

bind lookahead_adder lookahead_adder_chk #(
  .WIDTH (WIDTH),
  .GROUPS(GROUPS),
  .BLK   (BLK)
) chk_i (
  .opA     (opA),
  .opB     (opB),
  .carryIn (carryIn),
  .sumOut  (sumOut),
  .carryOut(carryOut),
  .blkCarry(blkCarry)
);

// File: tb/lookahead_adder_test.sv
module lookahead_adder_test;

  localparam int W     = 32;
  localparam int NVEC  = 13;
  localparam int NRAND = 300;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  int runCnt  = 0;
  int failCnt = 0;
  bit done    = 1'b0;

  lookahead_adder #(.WIDTH(W), .BLK(4)) uut (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );

  localparam logic [W-1:0] vecA [NVEC] = '{
    32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAAAAAAAA,
    32'hAAAAAAAA, 32'h0000000F, 32'h0FFFFFFF, 32'h12345678, 32'h80000000,
    32'hDEADBEEF, 32'h7FFFFFFF, 32'hF0F0F0F0};
  localparam logic [W-1:0] vecB [NVEC] = '{
    32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h55555555,
    32'h55555555, 32'h00000001, 32'h00000001, 32'h87654321, 32'h80000000,
    32'h00000000, 32'h00000001, 32'h0F0F0F0F};
  localparam logic vecC [NVEC] = '{
    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [W-1:0] vecS [NVEC] = '{
    32'h00000000, 32'h00000000, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h00000000, 32'h00000010, 32'h10000000, 32'h99999999, 32'h00000000,
    32'hDEADBEEF, 32'h80000000, 32'h00000000};
  localparam logic vecCo [NVEC] = '{
    1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string vecTag [NVEC] = '{
    "R1", "R3", "R4", "R4", "R5", "R3", "R6", "R6", "R1", "R2", "R7", "R6", "R3"};

  task automatic applyCheck(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic c, input logic [W-1:0] expS,
                            input logic expCo, input string tag);
    @(negedge clk);
    opA = a;
    opB = b;
    carryIn = c;
    #1;
    runCnt++;
    if (sumOut !== expS || carryOut !== expCo) begin
      failCnt++;
      $display("FAIL %s a=%h b=%h c=%b: got %b_%h expected %b_%h",
               tag, a, b, c, carryOut, sumOut, expCo, expS);
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      runCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state with zero operands (R7, R1)
    applyCheck('0, '0, 1'b0, '0, 1'b0, "R7");

    for (int i = 0; i < NVEC; i++) begin
      applyCheck(vecA[i], vecB[i], vecC[i], vecS[i], vecCo[i], vecTag[i]);
    end

    // R6: carry entering each group boundary from below
    for (int j = 1; j < 8; j++) begin
      logic [W-1:0] lowOnes;
      lowOnes = (32'h1 << (4 * j)) - 32'h1;
      applyCheck(lowOnes, '0, 1'b1, 32'h1 << (4 * j), 1'b0, "R6");
    end

    // R5: alternating complement patterns without carry-in
    applyCheck(32'h0F0F0F0F, 32'hF0F0F0F0, 1'b0, 32'hFFFFFFFF, 1'b0, "R5");

    // R7: identity with a random operand
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] r;
      r = $urandom;
      applyCheck(r, '0, 1'b0, r, 1'b0, "R7");
    end

    // R1 and R2: random operands against a behavioural add
    for (int i = 0; i < NRAND; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         c;
      logic [W:0]   full;
      a = $urandom;
      b = $urandom;
      c = 1'($urandom);
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      applyCheck(a, b, c, full[W-1:0], full[W], "R1");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule